// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block turns a system clock into the bit timing of a CAN receiver node. A prescaler divides the clock into time quanta. A segment sequencer then walks each bit through a one-quantum sync segment, a first time segment (propagation plus phase segment 1) and phase segment 2. The sample point is the end of the first time segment, and the bus level is read there.

The received line passes through a clock-domain synchronizer. A level change between two consecutive quanta counts as an edge. While the frame logic reports the bus as idle, a recessive-to-dominant edge hard-synchronizes the node: the quantum holding the edge becomes the sync segment of a fresh bit. While a frame is in progress, edges of either polarity resynchronize the node. An edge before the sample point stretches phase segment 1. An edge after it shrinks phase segment 2. The jump width caps the adjustment, and only one synchronization is allowed per bit.

The outputs are a one-cycle sample strobe, the sampled level and a one-cycle bit-start strobe. The bit-start strobe marks the end of each sync segment.

Top module: `can_bit_sync`

## Requirements
- R1: One quantum lasts `tq_div` clock cycles, and a value of 0 acts as 1. With no edges, a bit lasts (1 + `prop_len` + `ps1_len` + `ps2_len`) quanta between successive `bit_start` pulses, and every strobe is issued on a quantum boundary.
- R2: With no edges, `sample_stb` pulses `prop_len` + `ps1_len` quanta after each `bit_start` pulse.
- R3: `sample_bit` takes the synchronized bus level (1 = recessive, 0 = dominant) on each `sample_stb` pulse and holds it until the next pulse.
- R4: While `bus_idle` is 1, a 1-to-0 bus edge restarts the bit. The quantum containing the edge becomes the sync segment, and `bit_start` pulses at its end.
- R5: While `bus_idle` is 1, a 0-to-1 bus edge has no effect on timing.
- R6: While `bus_idle` is 0, an edge in quantum k of the first time segment (k = 1 for the quantum right after sync) lengthens phase segment 1 by min(k, `sjw_len`) quanta.
- R7: While `bus_idle` is 0, an edge in phase segment 2 with m quanta left in the bit, the edge quantum included, shortens phase segment 2 by min(m, `sjw_len`) quanta.
- R8: When the shortening in R7 equals m, the edge quantum becomes the sync segment of the next bit, and `bit_start` pulses at its end.
- R9: An edge that falls in the sync segment leaves the timing unchanged.
- R10: At most one synchronization, hard or resync, happens per bit. Later edges in the same bit are ignored.
- R11: While `bus_idle` is 0, both 1-to-0 and 0-to-1 edges resynchronize.
- R12: While `rst` is high, `sample_stb`, `sample_bit` and `bit_start` are 0. After release, timing starts in the sync segment, so `bit_start` pulses at the first quantum boundary.
- R13: `sample_stb` lasts one cycle and never coincides with `bit_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tq_div | input | DIV_W | Clock cycles per time quantum |
| prop_len | input | SEG_W | Propagation segment length in quanta |
| ps1_len | input | SEG_W | Phase segment 1 length in quanta |
| ps2_len | input | SEG_W | Phase segment 2 length in quanta |
| sjw_len | input | SJW_W | Resynchronization jump width in quanta |
| bus_idle | input | 1 | High while no frame is in progress (hard sync armed) |
| rx_in | input | 1 | Asynchronous received bus line |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| sample_bit | output | 1 | Bus level taken at the last sample point |
| bit_start | output | 1 | One-cycle pulse at the end of each sync segment |

## Verification
The bench uses the default widths and runs with propagation 2, phase segment 1 of 4, phase segment 2 of 4 and jump width 3, which gives an 11-quantum bit. With these values a positive error both below and above the jump width can be reached. Phase segment 2 can be shortened both partially and all the way to the edge quantum, and the sync segment can also be hit. Quanta of one clock make each quantum position reachable by a chosen drive instant. Later runs with a divide of 3 and of 0 cover the prescaler's scaling and its zero case.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   cnt_nxt;

  // a divide value of zero yields a tick every cycle
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign tick    = (cnt_nxt >= {1'b0, div});

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_in,
  output logic rx_lvl,
  output logic edge_det
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= rx_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], rx_in};
      end
    end
  endgenerate

  assign rx_lvl = sync_q[STAGES-1];

  // level seen at the previous quantum boundary
  always_ff @(posedge clk) begin
    if (rst)       last_q <= 1'b1;
    else if (tick) last_q <= rx_lvl;
  end

  assign edge_det = tick && (rx_lvl != last_q);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq #(
  parameter int SEG_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             edge_det,
  input  logic             rx_lvl,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ps1_len,
  input  logic [SEG_W-1:0] ps2_len,
  input  logic [SJW_W-1:0] sjw_len,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);
  import can_bt_pkg::*;

  localparam int CNT_W = SEG_W + 2;

  seg_e             seg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] t1_lim_q;
  logic             synced_q;

  logic [CNT_W-1:0] nom_t1, ps2_x, sjw_x, cnt_inc;
  logic [CNT_W-1:0] pos_adj, neg_err, neg_adj, t1_eff, cnt_skip;
  logic             hard_go, resync_go;

  always_comb begin
    nom_t1    = CNT_W'(prop_len) + CNT_W'(ps1_len);
    ps2_x     = CNT_W'(ps2_len);
    sjw_x     = CNT_W'(sjw_len);
    cnt_inc   = cnt_q + 1'b1;
    // positive error: quanta elapsed since the sync segment
    pos_adj   = (cnt_inc < sjw_x) ? cnt_inc : sjw_x;
    // negative error: quanta left in the bit, edge quantum included
    neg_err   = ps2_x - cnt_q;
    neg_adj   = (neg_err < sjw_x) ? neg_err : sjw_x;
    hard_go   = edge_det && bus_idle && !rx_lvl && !synced_q;
    resync_go = edge_det && !bus_idle && !synced_q;
    t1_eff    = resync_go ? (t1_lim_q + pos_adj) : t1_lim_q;
    cnt_skip  = cnt_inc + neg_adj;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q      <= SEG_SYNC;
      cnt_q      <= '0;
      t1_lim_q   <= '0;
      synced_q   <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b0;
      bit_start  <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      bit_start  <= 1'b0;
      if (tick) begin
        if (hard_go) begin
          // the quantum just ended becomes the sync segment
          seg_q     <= SEG_TS1;
          cnt_q     <= '0;
          t1_lim_q  <= nom_t1;
          synced_q  <= 1'b1;
          bit_start <= 1'b1;
        end else begin
          unique case (seg_q)
            SEG_SYNC: begin
              seg_q     <= SEG_TS1;
              cnt_q     <= '0;
              t1_lim_q  <= nom_t1;
              synced_q  <= resync_go;
              bit_start <= 1'b1;
            end
            SEG_TS1: begin
              t1_lim_q <= t1_eff;
              if (resync_go) synced_q <= 1'b1;
              if (cnt_inc >= t1_eff) begin
                sample_stb <= 1'b1;
                sample_bit <= rx_lvl;
                seg_q      <= SEG_TS2;
                cnt_q      <= '0;
              end else begin
                cnt_q <= cnt_inc;
              end
            end
            SEG_TS2: begin
              if (resync_go) begin
                synced_q <= 1'b1;
                if (neg_adj == neg_err) begin
                  seg_q     <= SEG_TS1;
                  cnt_q     <= '0;
                  t1_lim_q  <= nom_t1;
                  bit_start <= 1'b1;
                end else if (cnt_skip >= ps2_x) begin
                  seg_q <= SEG_SYNC;
                  cnt_q <= '0;
                end else begin
                  cnt_q <= cnt_skip;
                end
              end else if (cnt_inc >= ps2_x) begin
                seg_q <= SEG_SYNC;
                cnt_q <= '0;
              end else begin
                cnt_q <= cnt_inc;
              end
            end
            default: begin
              seg_q <= SEG_SYNC;
              cnt_q <= '0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync #(
  parameter int DIV_W       = 8,
  parameter int SEG_W       = 4,
  parameter int SJW_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] tq_div,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ps1_len,
  input  logic [SEG_W-1:0] ps2_len,
  input  logic [SJW_W-1:0] sjw_len,
  input  logic             bus_idle,
  input  logic             rx_in,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);
  logic tq_tick;
  logic rx_lvl;
  logic edge_det;

  can_bt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .div  (tq_div),
    .tick (tq_tick)
  );

  can_bt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .tick     (tq_tick),
    .rx_in    (rx_in),
    .rx_lvl   (rx_lvl),
    .edge_det (edge_det)
  );

  can_bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tq_tick),
    .edge_det   (edge_det),
    .rx_lvl     (rx_lvl),
    .bus_idle   (bus_idle),
    .prop_len   (prop_len),
    .ps1_len    (ps1_len),
    .ps2_len    (ps2_len),
    .sjw_len    (sjw_len),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .bit_start  (bit_start)
  );
endmodule

// File: rtl/can_bit_sync_chk.sv
module can_bit_sync_chk (
  input logic clk,
  input logic rst,
  input logic tq_tick,
  input logic sample_stb,
  input logic sample_bit,
  input logic bit_start
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d) begin
      AST_RESET_QUIET: assert (!sample_stb && !bit_start && !sample_bit) // R12
        else $error("outputs active during reset");
    end
  end

  AST_SAMPLE_ON_QUANTUM: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> $past(tq_tick)) else $error("sample off boundary"); // R1

  AST_START_ON_QUANTUM: assert property (@(posedge clk) disable iff (rst)
    bit_start |-> $past(tq_tick)) else $error("bit start off boundary"); // R1

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_bit) |-> sample_stb) else $error("sample bit moved"); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_start)) else $error("strobes overlap"); // R13

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb) else $error("sample strobe too long"); // R13
endmodule

bind can_bit_sync can_bit_sync_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tq_tick    (tq_tick),
  .sample_stb (sample_stb),
  .sample_bit (sample_bit),
  .bit_start  (bit_start)
);

// File: tb/can_bit_sync_bench.sv
module can_bit_sync_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 9;
  // drive offset, first sample, first bit start, second sample, second bit start
  localparam int VEC [NV][5] = '{
    '{0,  9, 14, 20, 25},
    '{2,  9, 14, 20, 25},
    '{9,  6, 11, 18, 23},
    '{10, 6, 11, 19, 24},
    '{4,  6,  8, 14, 19},
    '{5,  6,  8, 14, 19},
    '{6,  6,  9, 15, 20},
    '{7,  6, 10, 16, 21},
    '{8,  6, 11, 17, 22}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tq_div = 8'd1;
  logic [3:0] prop_len = 4'd2;
  logic [3:0] ps1_len = 4'd4;
  logic [3:0] ps2_len = 4'd4;
  logic [2:0] sjw_len = 3'd3;
  logic       bus_idle = 1'b0;
  logic       rx_in = 1'b1;
  logic       sample_stb, sample_bit, bit_start;

  int n_chk = 0;
  int n_bad = 0;
  int n_overlap = 0;
  bit done = 1'b0;

  can_bit_sync u_can_bit_sync (
    .clk        (clk),
    .rst        (rst),
    .tq_div     (tq_div),
    .prop_len   (prop_len),
    .ps1_len    (ps1_len),
    .ps2_len    (ps2_len),
    .sjw_len    (sjw_len),
    .bus_idle   (bus_idle),
    .rx_in      (rx_in),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .bit_start  (bit_start)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (!rst && sample_stb && bit_start) n_overlap++;

  function automatic string vtag(input int i);
    case (i)
      4:       return "R7";
      5, 6:    return "R8";
      7:       return "R11";
      8:       return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input int d, input int d2, input int win,
                         output int sp1, output int bs1, output int sp2,
                         output int bs2, output int sb2);
    sp1 = -1; bs1 = -1; sp2 = -1; bs2 = -1; sb2 = -1;
    do @(negedge clk); while (!bit_start);
    if (d == 0) rx_in = ~rx_in;
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      if (k == d)  rx_in = ~rx_in;
      if (k == d2) rx_in = ~rx_in;
      if (sample_stb) begin
        if (sp1 < 0) sp1 = k;
        else if (sp2 < 0) begin sp2 = k; sb2 = int'(sample_bit); end
      end
      if (bit_start) begin
        if (bs1 < 0) bs1 = k;
        else if (bs2 < 0) bs2 = k;
      end
    end
  endtask

  task automatic expect4(input string tag, input int sp1, input int bs1, input int sp2,
                         input int bs2, input int e0, input int e1, input int e2, input int e3);
    check(tag, "first sample offset", sp1, e0);
    check(tag, "first bit start offset", bs1, e1);
    check(tag, "second sample offset", sp2, e2);
    check(tag, "second bit start offset", bs2, e3);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int sp1, bs1, sp2, bs2, sb2;
    int fbs, fsp;
    // R12: quiet during reset
    repeat (4) @(negedge clk);
    check("R12", "sample_stb in reset", int'(sample_stb), 0);
    check("R12", "bit_start in reset", int'(bit_start), 0);
    check("R12", "sample_bit in reset", int'(sample_bit), 0);
    rst = 1'b0;
    fbs = -1; fsp = -1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (bit_start && fbs < 0) fbs = k;
      if (sample_stb && fsp < 0) fsp = k;
    end
    check("R12", "first bit start after release", fbs, 1);
    check("R2", "first sample after release", fsp, 7);

    // table: edges at every quantum position, polarity alternating
    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i][0], -1, 40, sp1, bs1, sp2, bs2, sb2);
      expect4(vtag(i), sp1, bs1, sp2, bs2, VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      check("R3", "sampled level", sb2, int'(rx_in));
    end

    // R10: a second edge in the same bit is ignored
    run_vec(0, 3, 40, sp1, bs1, sp2, bs2, sb2);
    expect4("R10", sp1, bs1, sp2, bs2, 9, 14, 20, 25);
    check("R3", "sampled level after double edge", sb2, int'(rx_in));

    // R5: rising edge while idle leaves timing alone (line is low here)
    bus_idle = 1'b1;
    run_vec(1, -1, 40, sp1, bs1, sp2, bs2, sb2);
    expect4("R5", sp1, bs1, sp2, bs2, 6, 11, 17, 22);
    check("R3", "sampled level after idle rise", sb2, 1);

    // R4: falling edge while idle hard-synchronizes
    run_vec(1, -1, 40, sp1, bs1, sp2, bs2, sb2);
    expect4("R4", sp1, bs1, sp2, bs2, 10, 4, 21, 15);
    check("R3", "sampled level after hard sync", sb2, 0);
    bus_idle = 1'b0;

    // R1: prescaler scaling
    tq_div = 8'd3;
    run_vec(-1, -1, 70, sp1, bs1, sp2, bs2, sb2);
    expect4("R1", sp1, bs1, sp2, bs2, 18, 33, 51, 66);
    check("R2", "sample offset with divide 3", sp1, 18);

    tq_div = 8'd0;
    run_vec(-1, -1, 40, sp1, bs1, sp2, bs2, sb2);
    expect4("R1", sp1, bs1, sp2, bs2, 6, 11, 17, 22);

    check("R13", "strobe overlap count", n_overlap, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule